// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block is a purely combinational word shifter. It moves a 32-bit data word by a 5-bit distance in one of three directions and fills: toward the most significant end with zeros, toward the least significant end with zeros, or toward the least significant end with copies of the sign bit. A 2-bit mode input picks the direction and fill. The result appears on the output in the same cycle, with no clock or state.

The datapath is a chain of five conditional stages. Each stage moves the word by a fixed power of two (16, 8, 4, 2, 1) or passes it through, and one bit of the distance input enables it. A single right-shifting chain serves all modes. For the leftward mode, the word is bit-mirrored on entry and again on exit.

Top module: `log_shifter`

## Requirements
- R1: A distance of 0 drives `data_out` equal to `data_in` in every mode.
- R2: Mode code 2'b00 yields `data_in` shifted toward bit 31 by `shamt` places, with zeros in the vacated low bits.
- R3: Mode code 2'b01 gives the same result as mode 2'b00 for every data word and distance.
- R4: Mode code 2'b10 yields `data_in` shifted toward bit 0 by `shamt` places, with zeros in the vacated high bits.
- R5: Mode code 2'b11 yields `data_in` shifted toward bit 0 by `shamt` places, with the vacated high bits equal to `data_in[31]`. For example, 0xFFFFFFEC by 1 gives 0xFFFFFFF6.
- R6: Each of bits 4..0 of `shamt` independently adds a move of 16, 8, 4, 2 or 1 places. For example, a distance of 13 equals a move of 8, then 4, then 1.
- R7: At the largest distance (31), the leftward modes leave only `data_in[0]` at bit 31. The zero-fill rightward mode leaves only `data_in[31]` at bit 0. The sign-fill mode drives every bit to `data_in[31]`.
- R8: The output depends only on the present inputs and follows them without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| shamt | input | 5 | Shift distance, 0 to 31 |
| mode | input | 2 | 00/01 left zero-fill, 10 right zero-fill, 11 right sign-fill |
| data_out | output | 32 | Shifted word |

## Verification
The checks on vacated bits assume that every input is a known 0 or 1. The checker therefore evaluates only when `data_in`, `shamt` and `mode` carry no unknown bits. The bench drives all three from its first time step. It only changes them at the falling clock edge, and it samples the output one nanosecond later, after the combinational chain has settled.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    typedef enum logic [1:0] {
        MODE_SLL     = 2'b00,
        MODE_SLL_ALT = 2'b01,
        MODE_SRL     = 2'b10,
        MODE_SRA     = 2'b11
    } shift_mode_e;

    typedef struct packed {
        logic mirror;     // reverse bit order around the right-shift chain
        logic sign_fill;  // vacated bits take the sign instead of zero
    } shift_ctrl_t;

    function automatic shift_ctrl_t decode_mode(input logic [1:0] code);
        shift_ctrl_t c;
        c.mirror    = ~code[1];
        c.sign_fill = code[1] & code[0];
        return c;
    endfunction

endpackage

// File: rtl/bit_mirror.sv
module bit_mirror #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign dout[i] = din[WIDTH-1-i];
    end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);
    // Row of 2:1 selectors: keep bit i, or take the bit DIST places above.
    for (genvar i = 0; i < WIDTH; i++) begin : g_mux
        if (i + DIST < WIDTH) begin : g_src
            assign dout[i] = en ? din[i+DIST] : din[i];
        end else begin : g_fill
            assign dout[i] = en ? fill : din[i];
        end
    end
endmodule

// File: rtl/log_shifter.sv
module log_shifter
    import shifter_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] shamt,
    input  logic [1:0]       mode,
    output logic [WIDTH-1:0] data_out
);
    shift_ctrl_t      ctrl;
    logic [WIDTH-1:0] in_mirrored;
    logic [WIDTH-1:0] out_mirrored;
    logic [WIDTH-1:0] chain [AMT_W+1];
    logic             fill_bit;

    assign ctrl     = decode_mode(mode);
    assign fill_bit = ctrl.sign_fill & data_in[WIDTH-1];

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .din  (data_in),
        .dout (in_mirrored)
    );

    assign chain[0] = ctrl.mirror ? in_mirrored : data_in;

    // Largest distance first: stage s moves by 2**(AMT_W-1-s).
    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int BIT = AMT_W - 1 - s;
        shift_stage #(.WIDTH(WIDTH), .DIST(1 << BIT)) u_stage (
            .din  (chain[s]),
            .en   (shamt[BIT]),
            .fill (fill_bit),
            .dout (chain[s+1])
        );
    end

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .din  (chain[AMT_W]),
        .dout (out_mirrored)
    );

    assign data_out = ctrl.mirror ? out_mirrored : chain[AMT_W];

endmodule

// File: rtl/log_shifter_chk.sv
module log_shifter_chk #(
    parameter int WIDTH = 32,
    parameter int AMT_W = 5
) (
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] shamt,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] data_out
);
    logic [WIDTH-1:0] low_mask;
    logic [WIDTH-1:0] high_mask;
    logic             known;

    always_comb begin
        low_mask  = (WIDTH'(1) << shamt) - WIDTH'(1);
        high_mask = ~({WIDTH{1'b1}} >> shamt);
        known     = !$isunknown({data_in, shamt, mode});
        if (known) begin
            if (shamt == '0)
                AST_ZERO_PASS: assert (data_out == data_in); // R1
            if (mode[1] == 1'b0)
                AST_LEFT_LOW_ZERO: assert ((data_out & low_mask) == '0); // R2
            if (mode == 2'b10)
                AST_SRL_HIGH_ZERO: assert ((data_out & high_mask) == '0); // R4
            if (mode == 2'b11)
                AST_SRA_HIGH_SIGN: assert ((data_out & high_mask) == (data_in[WIDTH-1] ? high_mask : '0)); // R5
            if (mode == 2'b11 && shamt == AMT_W'(WIDTH-1))
                AST_SRA_FULL: assert (data_out == {WIDTH{data_in[WIDTH-1]}}); // R7
        end
    end
endmodule

bind log_shifter log_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .data_in  (data_in),
    .shamt    (shamt),
    .mode     (mode),
    .data_out (data_out)
);

// File: tb/tb_log_shifter.sv
`timescale 1ns/1ps
module tb_log_shifter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] data_in = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  mode = '0;
    logic [31:0] data_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    log_shifter dut (
        .data_in  (data_in),
        .shamt    (shamt),
        .mode     (mode),
        .data_out (data_out)
    );

    function automatic logic [31:0] model(logic [31:0] d, logic [4:0] a, logic [1:0] m);
        case (m)
            2'b10:   return d >> a;
            2'b11:   return 32'($signed(d) >>> a);
            default: return d << a;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] exp);
        checks++;
        if (data_out !== exp) begin
            errors++;
            $display("FAIL %s: data_in=%h shamt=%0d mode=%b actual=%h expected=%h",
                     req, data_in, shamt, mode, data_out, exp);
        end
    endtask

    task automatic apply(logic [31:0] d, logic [4:0] a, logic [1:0] m);
        @(negedge clk);
        data_in = d; shamt = a; mode = m;
        #1;
    endtask

    initial begin
        #20000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        check("R8 reset state", 32'h0);

        // Directed corners
        apply(32'hFFFF_FFEC, 5'd1, 2'b11);  check("R5 sign fill example", 32'hFFFF_FFF6);
        apply(32'h8000_0000, 5'd31, 2'b11); check("R7 sra full", 32'hFFFF_FFFF);
        apply(32'h7FFF_FFFF, 5'd31, 2'b11); check("R7 sra full positive", 32'h0);
        apply(32'h0000_0001, 5'd31, 2'b00); check("R7 sll full", 32'h8000_0000);
        apply(32'hFFFF_FFFE, 5'd31, 2'b01); check("R7 sll alt full", 32'h0);
        apply(32'h8000_0000, 5'd31, 2'b10); check("R7 srl full", 32'h1);
        apply(32'h0000_0001, 5'd13, 2'b00); check("R6 distance 13", 32'h0000_2000);
        apply(32'hA5A5_0000, 5'd13, 2'b10); check("R6 distance 13 right", 32'h0005_2D28);
        apply(32'hDEAD_BEEF, 5'd0, 2'b11);  check("R1 zero distance", 32'hDEAD_BEEF);

        // Sweep all modes and distances with random words
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 32; a++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [31:0] d;
                    d = $urandom();
                    if (k == 0) d[31] = 1'b1;
                    apply(d, 5'(a), 2'(m));
                    if (a == 0)       check("R1 passthrough", d);
                    else if (m == 0)  check("R2 left zero fill", model(d, 5'(a), 2'(m)));
                    else if (m == 1)  check("R3 alias of left", model(d, 5'(a), 2'b00));
                    else if (m == 2)  check("R4 right zero fill", model(d, 5'(a), 2'(m)));
                    else              check("R5 right sign fill", model(d, 5'(a), 2'(m)));
                end
            end
        end

        // Per-bit stage independence
        for (int b = 0; b < 5; b++) begin
            apply(32'h0000_0001, 5'(1 << b), 2'b00);
            check("R6 single stage", 32'h1 << (1 << b));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule